// File: doc/BRIEF.md
# Video Display Processor Host Port

This block is the processor-facing port of a tile-based video display processor. The processor sees two byte-wide locations, selected by one address line: a data location and a control location. Two back-to-back writes to the control location form one command. The first byte is always a payload byte. The two top bits of the second byte choose the command: load the video memory address for writing, load it for reading, or write one of eight mode registers.

After an address has been loaded, every access to the data location moves one byte to or from video memory. The internal address then steps by one, so a whole buffer streams through a single location with no further address writes. For reads, a read-ahead latch holds the next byte: the byte the processor receives was fetched earlier, and each read starts the fetch of the next one.

The block also decodes the three video-mode bits held in the mode registers into a mode identifier for the display logic. A synchronous byte array stands in for video memory. Its depth is a parameter, and the 14-bit address mirrors into it through its low bits.

Top module: `vdp_host_port`

## Requirements
- R1: After reset, all eight mode registers read 0, the mode identifier is Graphics I (code 0), the internal address is 0x0000, and the next control write is taken as a first byte.
- R2: Access is decoded as follows. `port_sel`=0 is the data location and `port_sel`=1 is the control location. A control write pair whose second byte has bits 7:6 = 01 loads the address: the first byte supplies bits 7:0 and bits 5:0 of the second byte supply bits 13:8. The next data write lands at that address.
- R3: Data writes that follow one another with no new address setup store into consecutive addresses.
- R4: When bits 7:6 of the second byte are 00, the pair loads the address and the byte at that address is prefetched into the read-ahead latch. Each data read returns the latch and refills it from the next address, so reads return consecutive bytes. The processor leaves at least one idle cycle after the setup before its first data access.
- R5: When bits 7:6 of the second byte are 10, the first byte is written to the mode register whose index is bits 2:0 of the second byte. Register n appears on `regs_o[8n+7:8n]`.
- R6: A control-location read or any data-location access makes the next control write count as a first byte. A control read returns 0x00.
- R7: The internal address is 14 bits wide and steps from 0x3FFF to 0x0000.
- R8: The mode bits are M1 = register 1 bit 4, M2 = register 1 bit 3 and M3 = register 0 bit 1. The combination (M1,M2,M3) maps to `mode_id` as follows: 000 → 0 (Graphics I), 001 → 1 (Graphics II / bitmap), 010 → 2 (Multicolor), 100 → 3 (Text). Any other combination maps to 4 (undefined).
- R9: A control pair whose second byte has bits 7:6 = 11 changes neither the address nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | One-cycle access strobe |
| we | input | 1 | 1 = write, 0 = read |
| port_sel | input | 1 | 0 = data location, 1 = control location |
| wdata | input | 8 | Byte written by the processor |
| rdata | output | 8 | Byte returned on reads (valid during the access cycle) |
| regs_o | output | 64 | The eight mode registers, register n in bits 8n+7:8n |
| mode_id | output | 3 | Decoded video mode |

## Verification
The hardest case to reach is a command stream left half finished. A first control byte is written and then abandoned by a control read or a data access, and the following pair must still decode correctly. The bench reaches this state with directed sequences. The random phase then mixes stray single control writes and control reads into the random operations, so the byte toggle is frequently left in its second-byte state. A reference model tracks the address, the latch and the memory contents, so any misread toggle shows up as a wrong byte on a later read.

// File: rtl/vdp_pkg.sv
// Package: shared widths, command codes and the mode decode for the host port.
// Assumes byte-wide processor accesses and a 14-bit video address space.
package vdp_pkg;

    localparam int BYTE_W  = 8;
    localparam int VADDR_W = 14;
    localparam int NUM_REG = 8;
    localparam int REG_IW  = $clog2(NUM_REG);

    // Command carried in bits 7:6 of the second control byte
    typedef enum logic [1:0] {
        CMD_RD_SETUP = 2'b00,
        CMD_WR_SETUP = 2'b01,
        CMD_REG_WR   = 2'b10,
        CMD_NONE     = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        MODE_GFX1  = 3'd0,
        MODE_GFX2  = 3'd1,
        MODE_MULTI = 3'd2,
        MODE_TEXT  = 3'd3,
        MODE_UNDEF = 3'd4
    } mode_e;

    // Bit positions of the mode bits inside their registers
    localparam int M3_REG = 0;
    localparam int M3_BIT = 1;
    localparam int M12_REG = 1;
    localparam int M1_BIT = 4;
    localparam int M2_BIT = 3;

    // Map the mode bit combination {m1,m2,m3} to a mode identifier
    function automatic mode_e decode_mode(input logic m1, input logic m2, input logic m3);
        case ({m1, m2, m3})
            3'b000:  return MODE_GFX1;
            3'b001:  return MODE_GFX2;
            3'b010:  return MODE_MULTI;
            3'b100:  return MODE_TEXT;
            default: return MODE_UNDEF;
        endcase
    endfunction

endpackage

// File: rtl/vdp_cmd_decoder.sv
// Module: control-port command decoder.
// Tracks the two-write byte toggle, keeps the first byte and decodes the
// second byte into address loads or register writes. Assumes one-cycle cs
// strobes. A control read or a data access clears the toggle.
module vdp_cmd_decoder
    import vdp_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = VADDR_W,
    parameter int IW = REG_IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          we,
    input  logic          port_sel,
    input  logic [DW-1:0] wdata,
    output logic          phase_o,
    output logic [DW-1:0] first_o,
    output logic          ld_addr_o,
    output logic          ld_read_o,
    output logic [AW-1:0] ld_val_o,
    output logic          reg_we_o,
    output logic [IW-1:0] reg_idx_o,
    output logic [DW-1:0] reg_val_o
);
    localparam int HI_W = AW - DW;

    logic          phase_q;
    logic [DW-1:0] first_q;
    logic          ctrl_wr, ctrl_rd, data_acc, second;
    cmd_e          kind;

    // Classify the access in this cycle
    always_comb begin
        ctrl_wr  = cs && we && port_sel;
        ctrl_rd  = cs && !we && port_sel;
        data_acc = cs && !port_sel;
        second   = ctrl_wr && phase_q;
        kind     = cmd_e'(wdata[DW-1 -: 2]);
    end

    // Byte toggle and first-byte holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            first_q <= '0;
        end else if (ctrl_wr) begin
            if (!phase_q) begin
                first_q <= wdata;
                phase_q <= 1'b1;
            end else begin
                phase_q <= 1'b0;
            end
        end else if (ctrl_rd || data_acc) begin
            phase_q <= 1'b0;
        end
    end

    // Decode the completed command
    always_comb begin
        ld_addr_o = second && (kind == CMD_RD_SETUP || kind == CMD_WR_SETUP);
        ld_read_o = second && (kind == CMD_RD_SETUP);
        reg_we_o  = second && (kind == CMD_REG_WR);
        ld_val_o  = {wdata[HI_W-1:0], first_q};
        reg_idx_o = wdata[IW-1:0];
        reg_val_o = first_q;
    end

    assign phase_o = phase_q;
    assign first_o = first_q;

endmodule

// File: rtl/vdp_addr_ctr.sv
// Module: video address counter.
// Loads a new address or steps by one, wrapping at the top of the address
// space. Assumes load and step are never requested in the same cycle; load wins.
module vdp_addr_ctr #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_q;

    // Address register with natural wrap on increment
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= load_val;
        else if (step) addr_q <= addr_q + 1'b1;
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/vdp_vram.sv
// Module: synchronous single-port byte memory standing in for video RAM.
// The read register updates only on a read request and so doubles as the
// read-ahead latch. Address bits above the depth mirror.
module vdp_vram #(
    parameter int DW    = 8,
    parameter int AW    = 14,
    parameter int DEPTH = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic          ren,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdat,
    output logic [DW-1:0] rdat
);
    localparam int RAW = $clog2(DEPTH);

    logic [DW-1:0]  mem [DEPTH];
    logic [RAW-1:0] idx;
    logic [DW-1:0]  q;

    assign idx = addr[RAW-1:0];

    // Array write port
    always_ff @(posedge clk) begin
        if (wen) mem[idx] <= wdat;
    end

    // Registered read port, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (ren) q <= mem[idx];
    end

    assign rdat = q;

endmodule

// File: rtl/vdp_mode_regs.sv
// Module: bank of write-only mode registers plus the video mode decode.
// One register is written per command; all are visible on a flat bus.
module vdp_mode_regs
    import vdp_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NR = NUM_REG,
    parameter int IW = REG_IW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [IW-1:0]  idx,
    input  logic [DW-1:0]  val,
    output logic [NR*DW-1:0] regs_o,
    output mode_e          mode_o
);
    logic [DW-1:0] r [NR];

    for (genvar g = 0; g < NR; g++) begin : g_reg
        // Register g captures the value when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)                          r[g] <= '0;
            else if (we && idx == IW'(g))        r[g] <= val;
        end
        assign regs_o[g*DW +: DW] = r[g];
    end

    // Decode the mode from the three scattered bits
    always_comb begin
        mode_o = decode_mode(r[M12_REG][M1_BIT], r[M12_REG][M2_BIT], r[M3_REG][M3_BIT]);
    end

endmodule

// File: rtl/vdp_host_port.sv
// Module: top of the host port. Joins the command decoder, address counter,
// video memory and mode registers. Data accesses step the address; a read
// setup schedules one prefetch in the following cycle. Assumes the processor
// leaves an idle cycle after a read setup.
module vdp_host_port
    import vdp_pkg::*;
#(
    parameter int DW         = BYTE_W,
    parameter int AW         = VADDR_W,
    parameter int NR         = NUM_REG,
    parameter int VRAM_DEPTH = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             we,
    input  logic             port_sel,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic [NR*DW-1:0] regs_o,
    output logic [2:0]       mode_id
);
    localparam int IW = $clog2(NR);

    logic          phase, ld_addr, ld_read, reg_we, pend_fetch;
    logic [DW-1:0] first_byte, reg_val, vram_q;
    logic [AW-1:0] ld_val, addr;
    logic [IW-1:0] reg_idx;
    logic          data_acc, step, vram_ren, vram_wen;
    mode_e         mode;

    vdp_cmd_decoder #(.DW(DW), .AW(AW), .IW(IW)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .port_sel(port_sel),
        .wdata(wdata), .phase_o(phase), .first_o(first_byte),
        .ld_addr_o(ld_addr), .ld_read_o(ld_read), .ld_val_o(ld_val),
        .reg_we_o(reg_we), .reg_idx_o(reg_idx), .reg_val_o(reg_val)
    );

    // Prefetch request one cycle after a read setup
    always_ff @(posedge clk) begin
        if (!rst_n) pend_fetch <= 1'b0;
        else        pend_fetch <= ld_read;
    end

    // Memory and counter control
    always_comb begin
        data_acc = cs && !port_sel;
        vram_wen = data_acc && we;
        vram_ren = (data_acc && !we) || pend_fetch;
        step     = data_acc || pend_fetch;
    end

    vdp_addr_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld_addr), .load_val(ld_val),
        .step(step), .addr_o(addr)
    );

    vdp_vram #(.DW(DW), .AW(AW), .DEPTH(VRAM_DEPTH)) u_vram (
        .clk(clk), .rst_n(rst_n), .wen(vram_wen), .ren(vram_ren),
        .addr(addr), .wdat(wdata), .rdat(vram_q)
    );

    vdp_mode_regs #(.DW(DW), .NR(NR), .IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .val(reg_val),
        .regs_o(regs_o), .mode_o(mode)
    );

    // Read mux: control reads return zero, data reads return the latch
    always_comb begin
        rdata   = port_sel ? '0 : vram_q;
        mode_id = 3'(mode);
    end

endmodule

// File: rtl/vdp_host_port_checker.sv
// Module: property checker for the host port, attached by bind.
module vdp_host_port_checker #(
    parameter int DW = 8,
    parameter int AW = 14,
    parameter int NR = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             we,
    input logic             port_sel,
    input logic [DW-1:0]    wdata,
    input logic             phase,
    input logic             pend_fetch,
    input logic [DW-1:0]    first_byte,
    input logic [AW-1:0]    addr,
    input logic [NR*DW-1:0] regs_o,
    input logic [2:0]       mode_id
);
    // R3 / R7: each data access advances the address by one, with wrap
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !port_sel && !pend_fetch) |=> addr == AW'($past(addr) + 1'b1));

    // R2: a write setup pair loads the assembled address
    a_r2_wr_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && port_sel && phase && wdata[7:6] == 2'b01)
        |=> addr == {$past(wdata[AW-DW-1:0]), $past(first_byte)});

    // R5: a register write pair stores the first byte in the indexed register
    a_r5_reg_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && port_sel && phase && wdata[7:6] == 2'b10)
        |=> regs_o[$past(wdata[2:0])*DW +: DW] == $past(first_byte));

    // R6: control reads and data accesses clear the toggle
    a_r6_toggle_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && (!port_sel || !we)) |=> !phase);

    // R9: the unused command leaves the address and registers alone
    a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && port_sel && phase && wdata[7:6] == 2'b11)
        |=> ($stable(addr) && $stable(regs_o)));

    // R8: mode identifier stays within its code range
    always @(posedge clk) begin
        if (rst_n) a_r8_mode_range: assert (mode_id <= 3'd4);
    end

endmodule

bind vdp_host_port vdp_host_port_checker #(.DW(DW), .AW(AW), .NR(NR)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .port_sel(port_sel),
    .wdata(wdata), .phase(phase), .pend_fetch(pend_fetch),
    .first_byte(first_byte), .addr(addr), .regs_o(regs_o), .mode_id(mode_id)
);

// File: tb/vdp_host_port_bench.sv
module vdp_host_port_bench;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0, port_sel = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [63:0] regs_o;
    logic [2:0]  mode_id;

    int compared = 0;
    int mismatched = 0;

    // Reference model state
    logic [7:0]  m_mem [DEPTH];
    logic [13:0] m_addr;
    logic [7:0]  m_latch;
    logic [7:0]  m_regs [8];

    always #5 clk = ~clk;

    vdp_host_port u_vdp_host_port (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .port_sel(port_sel),
        .wdata(wdata), .rdata(rdata), .regs_o(regs_o), .mode_id(mode_id)
    );

    function automatic logic [2:0] exp_mode();
        logic m1, m2, m3;
        m1 = m_regs[1][4]; m2 = m_regs[1][3]; m3 = m_regs[0][1];
        case ({m1, m2, m3})
            3'b000: return 3'd0;
            3'b001: return 3'd1;
            3'b010: return 3'd2;
            3'b100: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle access, then one idle cycle
    task automatic bus(input logic w, input logic sel, input logic [7:0] d, output logic [7:0] r);
        @(negedge clk);
        cs = 1'b1; we = w; port_sel = sel; wdata = d;
        #1 r = rdata;
        @(negedge clk);
        cs = 1'b0;
        @(negedge clk);
    endtask

    task automatic ctrl_wr(input logic [7:0] d);
        logic [7:0] r;
        bus(1'b1, 1'b1, d, r);
    endtask

    task automatic ctrl_rd(input string req);
        logic [7:0] r;
        bus(1'b0, 1'b1, 8'h00, r);
        check(req, r, 8'h00);
    endtask

    task automatic set_waddr(input logic [13:0] a);
        ctrl_wr(a[7:0]);
        ctrl_wr({2'b01, a[13:8]});
        m_addr = a;
    endtask

    task automatic set_raddr(input logic [13:0] a);
        ctrl_wr(a[7:0]);
        ctrl_wr({2'b00, a[13:8]});
        m_latch = m_mem[a % DEPTH];
        m_addr = a + 14'd1;
    endtask

    task automatic wreg(input logic [2:0] i, input logic [7:0] v);
        ctrl_wr(v);
        ctrl_wr({5'b10000, i});
        m_regs[i] = v;
    endtask

    task automatic data_wr(input logic [7:0] v);
        logic [7:0] r;
        bus(1'b1, 1'b0, v, r);
        m_mem[m_addr % DEPTH] = v;
        m_addr = m_addr + 14'd1;
    endtask

    task automatic data_rd(input string req);
        logic [7:0] r;
        bus(1'b0, 1'b0, 8'h00, r);
        check(req, r, m_latch);
        m_latch = m_mem[m_addr % DEPTH];
        m_addr = m_addr + 14'd1;
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 8; i++) check(req, regs_o[i*8 +: 8], m_regs[i]);
        check(req, mode_id, exp_mode());
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
        m_addr = '0; m_latch = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 regs", regs_o, 64'h0);
        check("R1 mode", mode_id, 3'd0);
        // R1: address 0 after reset, first control write is a first byte
        data_wr(8'hA5);
        set_raddr(14'h0000);
        data_rd("R1 addr zero");

        // Clear video memory to a known state
        set_waddr(14'h0000);
        for (int i = 0; i < DEPTH; i++) data_wr(8'h00);

        // R2 / R3: write setup then a stream
        set_waddr(14'h0123);
        for (int i = 0; i < 6; i++) data_wr(8'h10 + 8'(i));
        // R4: read back the stream via the read-ahead latch
        set_raddr(14'h0123);
        for (int i = 0; i < 6; i++) data_rd("R3 R4 stream");

        // R7: wrap at the top of the address space
        set_waddr(14'h3FFE);
        data_wr(8'hC1); data_wr(8'hC2); data_wr(8'hC3);
        set_raddr(14'h3FFE);
        data_rd("R7 wrap"); data_rd("R7 wrap"); data_rd("R7 wrap");

        // R5 / R8: each mode
        wreg(3'd0, 8'h00); wreg(3'd1, 8'h00); check_regs("R8 gfx1");
        wreg(3'd0, 8'h02); check_regs("R8 gfx2");
        wreg(3'd0, 8'h00); wreg(3'd1, 8'h08); check_regs("R8 multi");
        wreg(3'd1, 8'h10); check_regs("R8 text");
        wreg(3'd1, 8'h18); check_regs("R8 undef");
        for (int i = 0; i < 8; i++) wreg(3'(i), 8'h30 + 8'(i));
        check_regs("R5 all regs");

        // R6: stray first byte abandoned by a control read
        ctrl_wr(8'h77);
        ctrl_rd("R6 ctrl read zero");
        set_waddr(14'h0200);
        data_wr(8'h5A);
        set_raddr(14'h0200);
        data_rd("R6 after ctrl read");
        // R6: stray first byte abandoned by a data access
        set_waddr(14'h0210);
        ctrl_wr(8'h66);
        data_wr(8'h3C);
        set_waddr(14'h0220);
        data_wr(8'h3D);
        set_raddr(14'h0210);
        data_rd("R6 after data acc");
        set_raddr(14'h0220);
        data_rd("R6 after data acc");

        // R9: command 11 changes neither address nor registers
        set_waddr(14'h0300);
        data_wr(8'h01);
        ctrl_wr(8'h12);
        ctrl_wr(8'hC5);
        check_regs("R9 regs kept");
        data_wr(8'h02);
        set_raddr(14'h0300);
        data_rd("R9 addr kept"); data_rd("R9 addr kept");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 7);
            case (op)
                0: set_waddr(14'($urandom));
                1: set_raddr(14'($urandom));
                2, 3: data_wr(8'($urandom));
                4: data_rd("R4 random read");
                5: wreg(3'($urandom), 8'($urandom));
                6: begin ctrl_wr(8'($urandom)); ctrl_rd("R6 random"); end
                default: begin ctrl_wr(8'($urandom)); data_rd("R6 random abandon"); end
            endcase
        end
        check_regs("R5 R8 random");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule